// File: doc/BRIEF.md
# RC5 Infrared Frame Decoder

This block turns the demodulated output of an infrared receiver into decoded RC5 remote-control frames. The receiver line idles high. Every bit is split into two halves that carry the bit value and its complement, so each bit has a transition in its middle. The decoder waits for the falling edge in the middle of the first start bit and starts a tick timer there. From then on it tracks the transmitter's real bit period. Each mid-bit transition restarts the timer, and the count reached at that moment becomes the new period estimate. One sample is taken per bit, three quarters of a period after the last mid-bit edge. This point lies a quarter bit into the next bit. Transitions at bit boundaries are never looked for.

A frame is abandoned if the next mid-bit transition has not arrived seven quarters of a period after the previous one. After thirteen samples, from the second start bit through the last command bit, the decoder waits one more sample interval and then assembles the fields. The 7-bit command takes its top bit from the inverted second start bit. The toggle bit of the last accepted frame is kept. A frame whose toggle equals it is a held-down repeat and produces nothing. A frame whose toggle differs updates the outputs and raises a one-cycle strobe.

The tick is a parameterized number of system clocks (2 us at the default 125 MHz). All thresholds follow from the measured period, so the block accepts a range of transmitter speeds.

Top module: `rc5_rx`

## Requirements
- R1: After reset, `addrOut`, `cmdOut` and `toggleOut` are zero and `keyValid` is low. The stored toggle, which is `toggleOut`, is 0.
- R2: The line carries 14 bits in this order: start bit 1, start bit 2, toggle, address bits 4 down to 0, command bits 5 down to 0. A bit of value 1 is high in its first half and low in its second half, and a 0 is the reverse. `addrOut[4:0]` holds the five address bits with bit 4 the first received.
- R3: `cmdOut[5:0]` holds the six command bits with bit 5 the first received. `cmdOut[6]` is the inverse of the sampled second start bit.
- R4: Each bit is sampled when the tick timer reaches (period>>1)+(period>>2), counted from the previous mid-bit transition. Transitions at bit boundaries, which come before that point, have no effect.
- R5: The period estimate is loaded with the nominal value at the first falling edge. It is then replaced by the timer count at every later mid-bit transition, so frames whose bit period differs from the nominal one still decode correctly.
- R6: If the timer reaches period+(period>>1)+(period>>2) before the next mid-bit transition, or if the timer saturates, the frame is dropped. In that case there is no strobe, and the outputs and stored toggle keep their values.
- R7: A mid-bit transition that lands in the same cycle in which the timeout limit is reached is treated as a timeout. A transition one tick earlier is accepted.
- R8: A complete frame whose toggle bit equals the stored toggle raises no strobe and leaves all outputs unchanged.
- R9: A complete frame whose toggle bit differs from the stored toggle updates `addrOut`, `cmdOut` and `toggleOut`, and raises `keyValid` for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irIn | input | 1 | Demodulated receiver line, idle high; synchronized internally |
| addrOut | output | 5 | Address of the last accepted frame |
| cmdOut | output | 7 | Command of the last accepted frame, bit 6 recovered from the second start bit |
| toggleOut | output | 1 | Toggle bit of the last accepted frame |
| keyValid | output | 1 | One-cycle strobe when a newly pressed key's frame is accepted |

## Verification
The mid-bit resynchronization and the seven-quarter timeout can occur in the same cycle. This happens when the last command bit's first half is stretched so that its mid-bit transition reaches the timer exactly at the limit. The bench stretches it to exactly that length and expects the frame to be dropped with no strobe and the outputs held. It then repeats the frame one tick shorter and expects it to be accepted and scored. All accepted frames are compared in order against a queue of expected frames. Any strobe that arrives with the queue empty counts as a failure.

// File: rtl/rc5_pkg.sv
package rc5_pkg;
  localparam int RC5_ADDR_W  = 5;
  localparam int RC5_CMD_W   = 7;
  // samples taken after the first start bit: ST2, toggle, 5 address, 6 command
  localparam int RC5_SAMPLES = 13;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_EDGE
  } rc5_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic start;   // first falling edge: restart timer, load nominal period
    logic shift;   // capture the line into the frame register
    logic resync;  // mid-bit edge: load measured period, restart timer
    logic finish;  // frame complete: commit if toggle is new
  } rc5_ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic fallSeen;
    logic edgeSeen;
    logic samplePoint;
    logic overLimit;
    logic lastBit;
  } rc5_stat_t;
endpackage

// File: rtl/rc5_ctl.sv
module rc5_ctl
  import rc5_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rc5_stat_t statBus,
  output rc5_ctl_t  ctlBus
);

  rc5_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctlBus    = '0;
    unique case (state)
      ST_IDLE: begin
        if (statBus.fallSeen) begin
          ctlBus.start = 1'b1;
          nextState    = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        if (statBus.samplePoint) begin
          if (statBus.lastBit) begin
            ctlBus.finish = 1'b1;
            nextState     = ST_IDLE;
          end else begin
            ctlBus.shift = 1'b1;
            nextState    = ST_EDGE;
          end
        end
      end
      ST_EDGE: begin
        // the limit is checked before the edge: a tie drops the frame
        if (statBus.overLimit) begin
          nextState = ST_IDLE;
        end else if (statBus.edgeSeen) begin
          ctlBus.resync = 1'b1;
          nextState     = ST_SAMPLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rc5_dp.sv
module rc5_dp
  import rc5_pkg::*;
#(
  parameter int TICK_DIV    = 250,
  parameter int NOM_TICKS   = 889,
  parameter int CNT_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  irIn,
  input  rc5_ctl_t              ctlBus,
  output rc5_stat_t             statBus,
  output logic [RC5_ADDR_W-1:0] addrOut,
  output logic [RC5_CMD_W-1:0]  cmdOut,
  output logic                  toggleOut,
  output logic                  keyValid
);

  localparam int EXT_W   = CNT_W + 2;
  localparam int BC_W    = $clog2(RC5_SAMPLES + 1);
  localparam int ST2_POS = RC5_SAMPLES - 1;
  localparam int TOG_POS = RC5_SAMPLES - 2;
  localparam int ADR_LO  = RC5_CMD_W - 1;
  localparam logic [CNT_W-1:0] TMAX = '1;

  // input synchronizer plus one history stage for edge detection
  logic [SYNC_STAGES:0] syncQ;
  logic lineNow, linePrev;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-1:0], irIn};
  end

  assign lineNow  = syncQ[SYNC_STAGES-1];
  assign linePrev = syncQ[SYNC_STAGES];

  // tick prescaler
  logic tick;
  logic clrTimer;
  assign clrTimer = ctlBus.start | ctlBus.resync;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (rst || clrTimer)                      preCnt <= '0;
        else if (preCnt == DIV_W'(TICK_DIV - 1))  preCnt <= '0;
        else                                      preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == DIV_W'(TICK_DIV - 1));
    end
  endgenerate

  // saturating timer and period estimate
  logic [CNT_W-1:0] timer, period;

  always_ff @(posedge clk) begin
    if (rst || clrTimer)               timer <= '0;
    else if (tick && timer != TMAX)    timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || ctlBus.start) period <= CNT_W'(NOM_TICKS);
    else if (ctlBus.resync)  period <= timer;
  end

  logic [EXT_W-1:0] timerExt, threeQ, sevenQ;
  assign timerExt = EXT_W'(timer);
  assign threeQ   = EXT_W'(period >> 1) + EXT_W'(period >> 2);
  assign sevenQ   = EXT_W'(period) + threeQ;

  // sample counter and frame register
  logic [BC_W-1:0]        bitCnt;
  logic [RC5_SAMPLES-1:0] frameSh;

  always_ff @(posedge clk) begin
    if (rst || ctlBus.start) bitCnt <= '0;
    else if (ctlBus.shift)   bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               frameSh <= '0;
    else if (ctlBus.shift) frameSh <= {frameSh[RC5_SAMPLES-2:0], lineNow};
  end

  // status back to control
  assign statBus.fallSeen    = linePrev & ~lineNow;
  assign statBus.edgeSeen    = linePrev ^ lineNow;
  assign statBus.samplePoint = (timerExt >= threeQ);
  assign statBus.overLimit   = (timerExt >= sevenQ) || (timer == TMAX);
  assign statBus.lastBit     = (bitCnt == BC_W'(RC5_SAMPLES));

  // commit only frames whose toggle differs from the stored one
  always_ff @(posedge clk) begin
    if (rst) begin
      addrOut   <= '0;
      cmdOut    <= '0;
      toggleOut <= 1'b0;
      keyValid  <= 1'b0;
    end else begin
      keyValid <= 1'b0;
      if (ctlBus.finish && (frameSh[TOG_POS] != toggleOut)) begin
        toggleOut <= frameSh[TOG_POS];
        addrOut   <= frameSh[TOG_POS-1 -: RC5_ADDR_W];
        cmdOut    <= {~frameSh[ST2_POS], frameSh[ADR_LO-1:0]};
        keyValid  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rc5_rx.sv
module rc5_rx
  import rc5_pkg::*;
#(
  parameter int TICK_DIV  = 250,
  parameter int NOM_TICKS = 889,
  parameter int CNT_W     = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       irIn,
  output logic [4:0] addrOut,
  output logic [6:0] cmdOut,
  output logic       toggleOut,
  output logic       keyValid
);

  rc5_ctl_t  ctlBus;
  rc5_stat_t statBus;

  rc5_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .statBus (statBus),
    .ctlBus  (ctlBus)
  );

  rc5_dp #(
    .TICK_DIV    (TICK_DIV),
    .NOM_TICKS   (NOM_TICKS),
    .CNT_W       (CNT_W),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .irIn      (irIn),
    .ctlBus    (ctlBus),
    .statBus   (statBus),
    .addrOut   (addrOut),
    .cmdOut    (cmdOut),
    .toggleOut (toggleOut),
    .keyValid  (keyValid)
  );

endmodule

// File: rtl/rc5_rx_chk.sv
module rc5_rx_chk
  import rc5_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     keyValid,
  input logic     toggleOut,
  input logic [4:0] addrOut,
  input logic [6:0] cmdOut,
  input rc5_ctl_t ctlBus
);

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    keyValid |=> !keyValid);

  // R8
  outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !keyValid |-> $stable({addrOut, cmdOut, toggleOut}));

  // R9
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    keyValid |-> (toggleOut != $past(toggleOut)));

  // R6
  strobe_after_finish_chk: assert property (@(posedge clk) disable iff (rst)
    keyValid |-> $past(ctlBus.finish));

endmodule

bind rc5_rx rc5_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .keyValid  (keyValid),
  .toggleOut (toggleOut),
  .addrOut   (addrOut),
  .cmdOut    (cmdOut),
  .ctlBus    (ctlBus)
);

// File: tb/tb_rc5_rx.sv
module tb_rc5_rx;
  localparam int HALF = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irIn = 1'b1;
  logic [4:0] addrOut;
  logic [6:0] cmdOut;
  logic toggleOut, keyValid;

  always #4 clk = ~clk;

  rc5_rx #(.TICK_DIV(1), .NOM_TICKS(199), .CNT_W(11)) dut (
    .clk(clk), .rst(rst), .irIn(irIn),
    .addrOut(addrOut), .cmdOut(cmdOut), .toggleOut(toggleOut), .keyValid(keyValid)
  );

  typedef struct {
    logic [4:0] a;
    logic [6:0] c;
    logic       t;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, errors = 0, strobes = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic checkHeld(input logic [4:0] a, input logic [6:0] c, input logic t, input string req);
    @(negedge clk);
    check(addrOut == a, req, addrOut, a);
    check(cmdOut == c, req, cmdOut, c);
    check(toggleOut == t, req, toggleOut, t);
  endtask

  // driver: pushes the expected result, then drives the line
  task automatic sendFrame(input logic tog, input logic [4:0] a, input logic [6:0] c,
                           input int half, input int nBits, input int lastExtra,
                           input bit wantIt, input string tag);
    logic [13:0] bits;
    bits = {1'b1, ~c[6], tog, a, c[5:0]};
    if (wantIt) expQ.push_back('{a, c, tog, tag});
    for (int i = 13; i > 13 - nBits; i--) begin
      irIn <= bits[i];
      waitClk(half + ((i == 0) ? lastExtra : 0));
      irIn <= ~bits[i];
      waitClk(half);
    end
    irIn <= 1'b1;
    waitClk(700);
  endtask

  // monitor: compares each strobe with the queue head
  always @(negedge clk) begin
    if (!rst && keyValid) begin
      strobes++;
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(addrOut == e.a, {e.tag, " R2 addr"}, addrOut, e.a);
        check(cmdOut == e.c, {e.tag, " R3 cmd"}, cmdOut, e.c);
        check(toggleOut == e.t, {e.tag, " R9 toggle"}, toggleOut, e.t);
      end
    end
  end

  initial begin
    waitClk(200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitClk(10);
    @(negedge clk);
    // R1 reset state
    check(addrOut == 5'd0, "R1 addr", addrOut, 0);
    check(cmdOut == 7'd0, "R1 cmd", cmdOut, 0);
    check(toggleOut == 1'b0, "R1 toggle", toggleOut, 0);
    check(keyValid == 1'b0, "R1 strobe", keyValid, 0);
    rst = 1'b0;
    waitClk(50);

    // new key, runs of equal bits exercise ignored boundary edges (R4)
    sendFrame(1'b1, 5'h05, 7'h23, HALF, 14, 0, 1'b1, "R2 R4 new");
    // same toggle: repeat, suppressed
    sendFrame(1'b1, 5'h05, 7'h23, HALF, 14, 0, 1'b0, "R8");
    checkHeld(5'h05, 7'h23, 1'b1, "R8 held after repeat");
    // extended command: C6 from inverted second start bit
    sendFrame(1'b0, 5'h1F, 7'h7F, HALF, 14, 0, 1'b1, "R3 c6 set");
    // truncated after six bits: dropped
    sendFrame(1'b1, 5'h0A, 7'h15, HALF, 6, 0, 1'b0, "R6");
    checkHeld(5'h1F, 7'h7F, 1'b0, "R6 held after timeout");
    // slower transmitter, toggle still differs from stored 0
    sendFrame(1'b1, 5'h00, 7'h40, HALF + 20, 14, 0, 1'b1, "R5 R6 slow bits");
    // last mid-bit edge exactly at the 7/4 limit: timeout wins
    sendFrame(1'b0, 5'h11, 7'h0C, HALF, 14, 148, 1'b0, "R7");
    checkHeld(5'h00, 7'h40, 1'b1, "R7 tie dropped");
    // one tick earlier: accepted
    sendFrame(1'b0, 5'h11, 7'h0C, HALF, 14, 147, 1'b1, "R7 R5 late edge");

    waitClk(20);
    check(strobes == 4, "R9 strobe count", strobes, 4);
    check(expQ.size() == 0, "R6 missing strobes", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule